// File: doc/BRIEF.md
# Chunked SPI Master with Local Byte Buffers

This block is an SPI master that moves whole chunks of bytes instead of single words. Software fills a byte-wide command buffer over a simple register bus. It then programs one control word with the chunk length, a clock speed code, the SPI mode and the target device. Setting the go bit in that same write starts the chunk. The engine shifts every byte out on MOSI, most significant bit first. Each byte sampled on MISO in the same slot is written into a separate response buffer at the same index.

When the last byte has been shifted, a completion event is latched. Software clears the event by writing 1 to it, and can mask it from the interrupt line. A hold bit keeps the selected chip select asserted after a chunk ends. Several go commands can therefore form one continuous transaction on the wire.

Register reads return data in the cycle after the read strobe. The command buffer starts at byte address 0x000 and the response buffer at 0x200; each byte has its own address and uses data bits 7:0. The control word is at 0x400, the event word at 0x420 and the mask word at 0x424.

Top module: `spi_chunk_master`

## Requirements
- R1: After reset the chip-select lines are all high, SCK and MOSI are low, the interrupt is low, the control word reads 0, the event word reads 0 and the mask word reads 0x100 (masked).
- R2: Writing the control word with bit 0 (go) set starts a transfer. The transfer sends the programmed number of bytes (bits 16:8) from command buffer index 0 upward, most significant bit first.
- R3: The byte received in each byte slot is stored in the response buffer at the same index, readable at 0x200 plus the index.
- R4: Control bit 2 selects the SPI mode: 0 gives mode 0 with SCK idle low, 1 gives mode 3 with SCK idle high. In both modes MISO is sampled on the rising SCK edge and MOSI changes on the falling edge.
- R5: The speed code in bits 7:5 sets the SCK period in system clocks: codes 2 to 6 give that many clocks, code 7 gives 32 clocks, and codes 0 and 1 act as code 2.
- R6: The chip-select outputs are active low and never more than one is low. Device select bits 27:25 with value 0 to 6 pick that line; value 7 picks none.
- R7: A finished chunk sets bit 8 of the event word. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: The interrupt output is high exactly when event bit 8 is set and mask bit 8 is 0.
- R9: While control bit 4 (hold) is 1, the selected chip select stays low after a chunk completes. It goes high once software writes the bit to 0.
- R10: Control bit 1 reads 1 while a chunk is pending or running, and the go bit always reads 0. A control write made while busy is discarded completely, including its go bit.
- R11: A go with length 0 sets the completion event within three clocks, without any SCK edge and without lowering a chip select.
- R12: A length above the buffer depth of 320 bytes is treated as 320 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register/buffer write strobe |
| reg_rd | input | 1 | Register/buffer read strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Completion interrupt, active high |
| spi_sck | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data to the devices |
| spi_miso | input | 1 | Serial data from the selected device |
| spi_cs_n | output | 7 | Active-low chip selects, one per device |

## Verification
The assertions take for granted that MISO changes only around falling SCK edges. They also assume a control write that lands while the engine is busy is a legal, discarded access and not a programming error. Finally, they assume a completion and an event clear may collide, with the completion winning.

The stimulus waits for the busy bit to drop before it reprograms the control word. It breaks that rule once on purpose, to show that a busy write is dropped. The device model changes MISO only on falling SCK, so every sampling edge sees settled data.

// File: rtl/spi_chunk_pkg.sv
// Shared constants, control-word layout and the speed-code mapping for the
// chunked SPI master. Assumes byte addressing on a 12-bit register bus.
package spi_chunk_pkg;

    localparam int ADDR_W   = 12;
    localparam int LEN_W    = 9;
    localparam int SLOW_DIV = 32;

    localparam logic [ADDR_W-1:0] OFF_CMD = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_RSP = 12'h200;
    localparam logic [ADDR_W-1:0] OFF_CTL = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_EVT = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_MSK = 12'h424;

    localparam int B_GO   = 0;
    localparam int B_BUSY = 1;
    localparam int B_MODE = 2;
    localparam int B_HOLD = 4;
    localparam int B_SPD  = 5;
    localparam int B_LEN  = 8;
    localparam int B_DEV  = 25;
    localparam int B_DONE = 8;

    typedef struct packed {
        logic [2:0]       dev;
        logic [LEN_W-1:0] len;
        logic [2:0]       spd;
        logic             hold_cs;
        logic             cpol_cpha;
    } ctl_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT} eng_state_t;

    // Speed code to SCK period in system clocks.
    function automatic int unsigned spd_to_div(input logic [2:0] code,
                                               input int unsigned slow);
        case (code)
            3'd3:    return 3;
            3'd4:    return 4;
            3'd5:    return 5;
            3'd6:    return 6;
            3'd7:    return slow;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/spi_chunk_buf.sv
// Byte-wide buffer with one synchronous write port and one asynchronous read
// port. Assumes indices below DEPTH; out-of-range reads return zero and
// out-of-range writes are dropped.
module spi_chunk_buf #(
    parameter int DEPTH = 320,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem [DEPTH];
    logic       wr_ok;

    assign wr_ok = wr_en && (int'(wr_idx) < DEPTH);

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_idx] <= wr_byte;
    end

    // Combinational read with range guard.
    always_comb begin
        rd_byte = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : 8'h00;
    end

    assert_buf_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH));

endmodule

// File: rtl/spi_chunk_regs.sv
// Register file: address decode, control word, completion event, mask,
// buffer access steering and registered read data. Assumes DEPTH <= 0x200
// so the two buffer windows do not overlap. Control writes while busy are
// dropped.
module spi_chunk_regs
    import spi_chunk_pkg::*;
#(
    parameter int DEPTH = 320,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              cmd_we,
    output logic [AW-1:0]     cmd_idx,
    output logic [7:0]        cmd_byte,
    output logic [AW-1:0]     rsp_idx,
    input  logic [7:0]        rsp_byte,
    output ctl_t              ctl,
    output logic              start,
    output logic              irq
);

    ctl_t       ctl_q;
    logic       start_q;
    logic       evt_q;
    logic       msk_q;
    logic       busy_all;
    logic       cmd_hit;
    logic       rsp_hit;
    logic       ctl_wr;
    logic       evt_wr;
    logic       msk_wr;
    logic [31:0] rd_mux;
    logic       unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[24:17], bus_wdata[3], bus_wdata[1]};

    assign cmd_hit = (bus_addr < OFF_RSP) && (bus_addr < ADDR_W'(DEPTH));
    assign rsp_hit = (bus_addr >= OFF_RSP) && (bus_addr < OFF_RSP + ADDR_W'(DEPTH));
    assign ctl_wr  = bus_wr && (bus_addr == OFF_CTL);
    assign evt_wr  = bus_wr && (bus_addr == OFF_EVT);
    assign msk_wr  = bus_wr && (bus_addr == OFF_MSK);

    assign cmd_we   = bus_wr && cmd_hit;
    assign cmd_idx  = AW'(bus_addr - OFF_CMD);
    assign cmd_byte = bus_wdata[7:0];
    assign rsp_idx  = AW'(bus_addr - OFF_RSP);

    assign busy_all = eng_busy || start_q;
    assign ctl      = ctl_q;
    assign start    = start_q;
    assign irq      = evt_q && !msk_q;

    // Control word capture and go pulse; both frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= ctl_wr && !busy_all && bus_wdata[B_GO];
            if (ctl_wr && !busy_all) begin
                ctl_q.dev       <= bus_wdata[B_DEV +: 3];
                ctl_q.len       <= bus_wdata[B_LEN +: LEN_W];
                ctl_q.spd       <= bus_wdata[B_SPD +: 3];
                ctl_q.hold_cs   <= bus_wdata[B_HOLD];
                ctl_q.cpol_cpha <= bus_wdata[B_MODE];
            end
        end
    end

    // Completion event: set by the engine, cleared by writing 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                           evt_q <= 1'b0;
        else if (eng_done)                    evt_q <= 1'b1;
        else if (evt_wr && bus_wdata[B_DONE]) evt_q <= 1'b0;
    end

    // Interrupt mask, masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      msk_q <= 1'b1;
        else if (msk_wr) msk_q <= bus_wdata[B_DONE];
    end

    // Read data selection by address.
    always_comb begin
        rd_mux = 32'h0;
        if (bus_addr == OFF_CTL)
            rd_mux = {4'b0, ctl_q.dev, 8'b0, ctl_q.len, ctl_q.spd, ctl_q.hold_cs,
                      1'b0, ctl_q.cpol_cpha, busy_all, 1'b0};
        else if (bus_addr == OFF_EVT)
            rd_mux = {23'b0, evt_q, 8'b0};
        else if (bus_addr == OFF_MSK)
            rd_mux = {23'b0, msk_q, 8'b0};
        else if (rsp_hit)
            rd_mux = {24'b0, rsp_byte};
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 32'h0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && busy_all) |=> ($stable(ctl_q) && !start_q));

    assert_done_sets_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> evt_q);

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && bus_wdata[B_DONE] && !eng_done) |=> !irq);

endmodule

// File: rtl/spi_chunk_engine.sv
// Shift engine: clock divider, bit and byte counters, full-duplex shifting,
// response write-back, chip-select decode and the hold latch. Assumes the
// control word is stable while busy (the register file guarantees this).
module spi_chunk_engine
    import spi_chunk_pkg::*;
#(
    parameter int DEPTH    = 320,
    parameter int AW       = $clog2(DEPTH),
    parameter int NCS      = 7,
    parameter int SLOW     = SLOW_DIV
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  ctl_t           ctl,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  cmd_idx,
    input  logic [7:0]     cmd_byte,
    output logic           rsp_we,
    output logic [AW-1:0]  rsp_idx,
    output logic [7:0]     rsp_byte,
    output logic           sck,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);

    localparam int CW = $clog2(SLOW + 1);

    eng_state_t       state;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    div;
    logic [CW-1:0]    lo_len;
    logic [2:0]       bitn;
    logic [LEN_W-1:0] byten;
    logic [LEN_W-1:0] eff_len;
    logic [7:0]       rx;
    logic             done_q;
    logic             held;
    logic             bit_end;
    logic             last_edge;
    logic             cs_act;

    assign div     = CW'(spd_to_div(ctl.spd, SLOW));
    assign lo_len  = div - (div >> 1);
    assign eff_len = (ctl.len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : ctl.len;

    assign bit_end   = (state == ST_SHIFT) && (cnt == div - 1'b1);
    assign last_edge = bit_end && (bitn == 3'd7) && (byten == eff_len - 1'b1);

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign cmd_idx  = AW'(byten);
    assign rsp_idx  = AW'(byten);
    assign rsp_we   = bit_end && (bitn == 3'd7);
    assign rsp_byte = rx;

    assign sck  = (state == ST_SHIFT) ? (cnt >= lo_len) : ctl.cpol_cpha;
    assign mosi = busy ? cmd_byte[3'd7 - bitn] : 1'b0;

    // Sequencer: start, lead-in, per-bit timing, byte stepping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            byten  <= '0;
            rx     <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        byten <= '0;
                        if (eff_len == '0) done_q <= 1'b1;
                        else               state  <= ST_LEAD;
                    end
                end
                ST_LEAD: state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (cnt == lo_len - 1'b1) rx <= {rx[6:0], miso};
                    if (bit_end) begin
                        cnt  <= '0;
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) byten <= byten + 1'b1;
                        if (last_edge) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Hold latch: keeps the select asserted between chunks while hold is set.
    always_ff @(posedge clk) begin
        if (!rst_n)            held <= 1'b0;
        else if (!ctl.hold_cs) held <= 1'b0;
        else if (last_edge)    held <= 1'b1;
    end

    assign cs_act = busy || held;

    // One active-low select per device index.
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(cs_act && (ctl.dev == 3'(i)));
    end

    assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_shift_selects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && int'(ctl.dev) < NCS) |-> !(&cs_n));

    assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE && eff_len == '0) |=> (state == ST_IDLE && done_q));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ctl.hold_cs && $past(!ctl.hold_cs)) |-> (&cs_n));

endmodule

// File: rtl/spi_chunk_master.sv
// Top of the chunked SPI master: register file, command and response
// buffers and the shift engine. Assumes DEPTH <= 0x200 and NCS <= 7.
module spi_chunk_master
    import spi_chunk_pkg::*;
#(
    parameter int DEPTH = 320,
    parameter int NCS   = 7,
    parameter int SLOW  = SLOW_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n
);

    localparam int AW = $clog2(DEPTH);

    ctl_t          ctl;
    logic          start;
    logic          eng_busy;
    logic          eng_done;
    logic          cmd_we;
    logic [AW-1:0] cmd_widx;
    logic [7:0]    cmd_wbyte;
    logic [AW-1:0] cmd_ridx;
    logic [7:0]    cmd_rbyte;
    logic          rsp_we;
    logic [AW-1:0] rsp_widx;
    logic [7:0]    rsp_wbyte;
    logic [AW-1:0] rsp_ridx;
    logic [7:0]    rsp_rbyte;

    spi_chunk_regs #(.DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(reg_wr), .bus_rd(reg_rd), .bus_addr(reg_addr),
        .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done),
        .cmd_we(cmd_we), .cmd_idx(cmd_widx), .cmd_byte(cmd_wbyte),
        .rsp_idx(rsp_ridx), .rsp_byte(rsp_rbyte),
        .ctl(ctl), .start(start), .irq(irq)
    );

    spi_chunk_buf #(.DEPTH(DEPTH), .AW(AW)) u_cmd_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_we), .wr_idx(cmd_widx), .wr_byte(cmd_wbyte),
        .rd_idx(cmd_ridx), .rd_byte(cmd_rbyte)
    );

    spi_chunk_buf #(.DEPTH(DEPTH), .AW(AW)) u_rsp_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rsp_we), .wr_idx(rsp_widx), .wr_byte(rsp_wbyte),
        .rd_idx(rsp_ridx), .rd_byte(rsp_rbyte)
    );

    spi_chunk_engine #(.DEPTH(DEPTH), .AW(AW), .NCS(NCS), .SLOW(SLOW)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(start), .ctl(ctl), .busy(eng_busy), .done(eng_done),
        .cmd_idx(cmd_ridx), .cmd_byte(cmd_rbyte),
        .rsp_we(rsp_we), .rsp_idx(rsp_widx), .rsp_byte(rsp_wbyte),
        .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso), .cs_n(spi_cs_n)
    );

endmodule

// File: tb/spi_chunk_master_test.sv
`timescale 1ns/1ps
module spi_chunk_master_test;

    localparam logic [11:0] A_RSP = 12'h200;
    localparam logic [11:0] A_CTL = 12'h400;
    localparam logic [11:0] A_EVT = 12'h420;
    localparam logic [11:0] A_MSK = 12'h424;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic [6:0]  spi_cs_n;

    int tests = 0;
    int fails = 0;

    spi_chunk_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #5 clk = ~clk;

    // Device model: captures MOSI on rising SCK, drives MISO on falling SCK.
    logic       sel;
    int         rises = 0;
    int         total_rises = 0;
    int         cs_low_cycles = 0;
    logic [7:0] cap [0:15];
    logic [7:0] cap_sh = '0;
    time        last_rise = 0;
    time        sck_period = 0;

    assign sel = ~&spi_cs_n;

    function automatic logic [7:0] sb(input int k);
        return 8'h3C ^ 8'(k * 37 + 1);
    endfunction

    always @(posedge sel) begin
        logic [7:0] b;
        rises = 0;
        b = sb(0);
        spi_miso = b[7];
    end

    always @(posedge spi_sck) begin
        total_rises++;
        sck_period = $time - last_rise;
        last_rise = $time;
        if (sel) begin
            cap_sh = {cap_sh[6:0], spi_mosi};
            rises++;
            if (rises % 8 == 0 && rises / 8 <= 16) cap[rises / 8 - 1] = cap_sh;
        end
    end

    always @(negedge spi_sck) begin
        logic [7:0] b;
        if (sel && rises > 0) begin
            b = sb(rises / 8);
            spi_miso = b[7 - (rises % 8)];
        end
    end

    always @(negedge clk) if (sel) cs_low_cycles++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctlw(input int dev, input int len, input int spd,
                                         input bit hold, input bit mode, input bit go);
        return {4'b0, 3'(dev), 8'b0, 9'(len), 3'(spd), hold, 1'b0, mode, 1'b0, go};
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(A_CTL, v);
            if (!v[1]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 cs_n", 32'(spi_cs_n), 32'h7F);
        check("R1 sck", 32'(spi_sck), 0);
        check("R1 mosi", 32'(spi_mosi), 0);
        check("R1 irq", 32'(irq), 0);
        rd(A_CTL, v); check("R1 ctl", v, 0);
        rd(A_EVT, v); check("R1 evt", v, 0);
        rd(A_MSK, v); check("R1 mask", v, 32'h100);
    endtask

    task automatic t_basic_mode0();
        logic [31:0] v;
        logic [7:0] tx [4] = '{8'hA5, 8'h0F, 8'h80, 8'h3C};
        for (int i = 0; i < 4; i++) wr(12'(i), 32'(tx[i]));
        wr(A_CTL, ctlw(2, 4, 2, 0, 0, 1));
        rd(A_CTL, v);
        check("R10 busy bit", 32'(v[1]), 1);
        check("R10 go reads 0", 32'(v[0]), 0);
        check("R6 select dev2", 32'(spi_cs_n), 32'h7B);
        wait_idle();
        for (int i = 0; i < 4; i++) check("R2 mosi byte", 32'(cap[i]), 32'(tx[i]));
        for (int i = 0; i < 4; i++) begin
            rd(A_RSP + 12'(i), v);
            check("R3 response byte", v, 32'(sb(i)));
        end
        check("R5 period code2", 32'(sck_period), 20);
        check("R4 mode0 idle low", 32'(spi_sck), 0);
        rd(A_EVT, v); check("R7 event set", v, 32'h100);
        check("R8 masked irq", 32'(irq), 0);
        wr(A_MSK, 0);
        @(negedge clk); check("R8 unmasked irq", 32'(irq), 1);
        wr(A_EVT, 0);
        rd(A_EVT, v); check("R7 write 0 keeps", v, 32'h100);
        wr(A_EVT, 32'h100);
        rd(A_EVT, v); check("R7 w1c", v, 0);
        check("R8 irq after clear", 32'(irq), 0);
    endtask

    task automatic t_mode3();
        logic [31:0] v;
        wr(0, 32'h5A); wr(1, 32'hC3);
        wr(A_CTL, ctlw(5, 2, 3, 0, 1, 0));
        @(negedge clk); check("R4 mode3 idle high", 32'(spi_sck), 1);
        wr(A_CTL, ctlw(5, 2, 3, 0, 1, 1));
        wait_idle();
        check("R2 mode3 byte0", 32'(cap[0]), 32'h5A);
        check("R2 mode3 byte1", 32'(cap[1]), 32'hC3);
        rd(A_RSP + 12'd1, v); check("R3 mode3 resp1", v, 32'(sb(1)));
        check("R5 period code3", 32'(sck_period), 30);
        check("R4 mode3 idle after", 32'(spi_sck), 1);
        wr(A_EVT, 32'h100);
    endtask

    task automatic t_speed_and_busy();
        logic [31:0] v;
        int r0;
        wr(A_CTL, ctlw(0, 1, 0, 0, 0, 1));
        wait_idle();
        check("R5 period code0", 32'(sck_period), 20);
        r0 = total_rises;
        wr(A_EVT, 32'h100);
        wr(A_CTL, ctlw(0, 3, 7, 0, 0, 1));
        wr(A_CTL, ctlw(3, 1, 2, 0, 0, 1));
        wait_idle();
        check("R5 period code7", 32'(sck_period), 320);
        rd(A_CTL, v); check("R10 busy write dropped", v, ctlw(0, 3, 7, 0, 0, 0));
        check("R10 edge count", 32'(total_rises - r0), 24);
        wr(A_EVT, 32'h100);
        repeat (50) @(negedge clk);
        rd(A_EVT, v); check("R10 no second chunk", v, 0);
    endtask

    task automatic t_devsel7();
        int c0, r0;
        c0 = cs_low_cycles; r0 = total_rises;
        wr(A_CTL, ctlw(7, 1, 2, 0, 0, 1));
        wait_idle();
        check("R6 dev7 no select", 32'(cs_low_cycles - c0), 0);
        check("R6 dev7 still shifts", 32'(total_rises - r0), 8);
        wr(A_EVT, 32'h100);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        wr(0, 32'h11); wr(1, 32'h22);
        wr(A_CTL, ctlw(1, 2, 2, 1, 0, 1));
        wait_idle();
        repeat (3) @(negedge clk);
        check("R9 held after chunk", 32'(spi_cs_n), 32'h7D);
        wr(0, 32'h33); wr(1, 32'h44);
        wr(A_CTL, ctlw(1, 2, 2, 1, 0, 1));
        wait_idle();
        check("R9 continued byte", 32'(cap[3]), 32'h44);
        rd(A_RSP, v); check("R9 resp continues", v, 32'(sb(2)));
        check("R9 still held", 32'(spi_cs_n), 32'h7D);
        wr(A_CTL, ctlw(1, 2, 2, 0, 0, 0));
        @(negedge clk);
        check("R9 released", 32'(spi_cs_n), 32'h7F);
        wr(A_EVT, 32'h100);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        int c0, r0;
        c0 = cs_low_cycles; r0 = total_rises;
        wr(A_CTL, ctlw(0, 0, 2, 0, 0, 1));
        @(negedge clk);
        rd(A_EVT, v); check("R11 event", v, 32'h100);
        check("R11 no sck", 32'(total_rises - r0), 0);
        check("R11 no select", 32'(cs_low_cycles - c0), 0);
        wr(A_EVT, 32'h100);
    endtask

    task automatic t_clamp();
        int r0;
        r0 = total_rises;
        wr(A_CTL, ctlw(4, 330, 2, 0, 0, 1));
        wait_idle();
        check("R12 clamped edges", 32'(total_rises - r0), 2560);
        wr(A_EVT, 32'h100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_mode0();
        t_mode3();
        t_speed_and_busy();
        t_devsel7();
        t_hold();
        t_zero_len();
        t_clamp();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule